// File: doc/BRIEF.md
# Snooping Coherence Controller with Transient Line States

This block keeps the coherence state of a small direct-mapped, write-back cache on an atomic snooping bus. A processor-side path looks up the line for one read or write request at a time and answers with a one-cycle completion pulse. A bus-side path asks an external arbiter for the bus and issues read, exclusive-read or upgrade transactions. It also snoops the transactions of other masters and answers with a flush or a stall. Data storage and arbitration sit outside. The block keeps only line states and tags, and holds the tags twice: one copy for the processor path and one for the snoop path.

Each line is in one of six states, coded I=0, S=1, M=2, SM=3, IM=4, IS=5. The transitions are named here. A read miss moves the line I to IS. A write miss moves it I to IM. A write hit in S moves it S to SM. When the grant arrives, IS goes to S, and SM and IM go to M. If another master wins the same block first, the upgrade race moves SM to IM. A snooped read takes M to S with a flush. A snooped exclusive read or upgrade takes S or M to I, and M also flushes. A write completes only after the transaction that makes it visible. While the processor access of the completion cycle runs, snoops to that block are held off with a stall, so a write that has just won a line cannot lose it before it lands.

Top module: `coh_ctrl`

## Requirements
- R1: After reset the controller is ready (`cpu_ready`=1), holds no bus request, asserts no completion, and every line is invalid, so the first access to any address misses.
- R2: A read that hits in S or M, or a write that hits in M, raises `cpu_done` in the cycle after acceptance and causes no bus request.
- R3: A read miss enters IS and requests the bus with command RD (`bus_cmd`=1). A write miss enters IM with RDX (`bus_cmd`=2). `bus_addr` is the request address, and the command stays up until granted.
- R4: A write that hits in S enters SM and requests the bus with UPG (`bus_cmd`=3). After the grant the line is M.
- R5: A line in SM that snoops RDX or UPG for its own block moves to IM, and from the next cycle the pending command is RDX instead of UPG.
- R6: `cpu_done` is a single-cycle pulse. For a miss or upgrade it comes in the cycle after the grant, and never earlier. `cpu_ready` is low from the cycle after acceptance up to and including the completion cycle.
- R7: A snooped RD that hits a line in M asserts `snp_flush` and leaves the line in S. A snooped RDX or UPG that hits S or M moves the line to I, with `snp_flush` only from M.
- R8: Lines in IS or IM ignore snoops to their own block. Snoops to other blocks during a pending miss are handled as in R7.
- R9: In the completion cycle, a snoop to the block of the completing request gets `snp_stall`=1, with no flush and no state change. It is handled once the snoop is presented again after that cycle.
- R10: In a cycle where a processor request is accepted, any snoop gets `snp_stall`=1 and changes nothing.
- R11: A miss that replaces a line in M records it as a dirty victim. `bus_wb` with `bus_wb_addr` equal to the victim address goes out in the grant cycle. If a snoop to the victim arrives first, that snoop is flushed instead and no writeback follows.
- R12: A snoop presented in this controller's own grant cycle is ignored: no flush, no stall, no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request valid |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Block address {tag, index} |
| cpu_ready | output | 1 | A request is accepted this cycle if presented |
| cpu_done | output | 1 | Completion pulse for the accepted request |
| bus_req | output | 1 | Bus request while a transaction is pending |
| bus_grant | input | 1 | Grant; the transaction happens in this cycle |
| bus_cmd | output | 2 | 0 none, 1 RD, 2 RDX, 3 UPG |
| bus_addr | output | ADDR_W | Address of the pending transaction |
| bus_wb | output | 1 | Victim writeback rides with this grant |
| bus_wb_addr | output | ADDR_W | Victim block address |
| snp_valid | input | 1 | Another master's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same coding as bus_cmd |
| snp_addr | input | ADDR_W | Snooped block address |
| snp_flush | output | 1 | This cache supplies dirty data |
| snp_stall | output | 1 | Snoop not complete, repeat it next cycle |

## Verification
Snoop handling can fall in the same cycle as a processor acceptance, a completion or this controller's own grant. These coincidences are the cases the bench drives on purpose. It presents a snoop exactly in the acceptance cycle, in the completion cycle of a fresh exclusive line, in the grant cycle, and while an upgrade is pending against the same block. A behavioural reference model predicts flush, stall, command and completion for every cycle. Later accesses then show through the ports whether a stalled or ignored snoop left the line untouched.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [2:0] {
        ST_I  = 3'd0,
        ST_S  = 3'd1,
        ST_M  = 3'd2,
        ST_SM = 3'd3,
        ST_IM = 3'd4,
        ST_IS = 3'd5
    } line_st_t;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_RD   = 2'd1,
        CMD_RDX  = 2'd2,
        CMD_UPG  = 2'd3
    } bus_cmd_t;

endpackage

// File: rtl/coh_lookup.sv
// Processor-side classification of one request against one line.
module coh_lookup
    import coh_pkg::*;
(
    input  line_st_t cur_st,
    input  logic     tag_hit,
    input  logic     wr,
    output logic     done_now,
    output logic     upd,
    output line_st_t nxt_st,
    output logic     miss,
    output logic     victim
);
    always_comb begin
        done_now = 1'b0;
        upd      = 1'b0;
        nxt_st   = cur_st;
        miss     = 1'b0;
        victim   = 1'b0;
        if (tag_hit && (cur_st == ST_S || cur_st == ST_M)) begin
            unique case (cur_st)
                ST_M: done_now = 1'b1;
                ST_S: begin
                    if (!wr) begin
                        done_now = 1'b1;
                    end else begin
                        upd    = 1'b1;
                        nxt_st = ST_SM;
                    end
                end
                default: done_now = 1'b0;
            endcase
        end else begin
            miss   = 1'b1;
            upd    = 1'b1;
            nxt_st = wr ? ST_IM : ST_IS;
            victim = (cur_st == ST_M) && !tag_hit;
        end
    end
endmodule

// File: rtl/coh_snoop.sv
// Bus-side reaction of one line to a snooped transaction.
module coh_snoop
    import coh_pkg::*;
(
    input  line_st_t cur_st,
    input  logic     tag_hit,
    input  bus_cmd_t cmd,
    output line_st_t nxt_st,
    output logic     chg,
    output logic     flush
);
    logic excl;
    assign excl = (cmd == CMD_RDX) || (cmd == CMD_UPG);

    always_comb begin
        nxt_st = cur_st;
        chg    = 1'b0;
        flush  = 1'b0;
        if (tag_hit) begin
            unique case (cur_st)
                ST_M: begin
                    if (cmd == CMD_RD) begin
                        nxt_st = ST_S;
                        chg    = 1'b1;
                        flush  = 1'b1;
                    end else if (excl) begin
                        nxt_st = ST_I;
                        chg    = 1'b1;
                        flush  = 1'b1;
                    end
                end
                ST_S: begin
                    if (excl) begin
                        nxt_st = ST_I;
                        chg    = 1'b1;
                    end
                end
                ST_SM: begin
                    if (excl) begin
                        nxt_st = ST_IM;
                        chg    = 1'b1;
                    end
                end
                default: chg = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/coh_ctrl.sv
module coh_ctrl
    import coh_pkg::*;
#(
    parameter int IDX_W = 2,
    parameter int TAG_W = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cpu_req,
    input  logic                          cpu_wr,
    input  logic [IDX_W+TAG_W-1:0]        cpu_addr,
    output logic                          cpu_ready,
    output logic                          cpu_done,
    output logic                          bus_req,
    input  logic                          bus_grant,
    output logic [1:0]                    bus_cmd,
    output logic [IDX_W+TAG_W-1:0]        bus_addr,
    output logic                          bus_wb,
    output logic [IDX_W+TAG_W-1:0]        bus_wb_addr,
    input  logic                          snp_valid,
    input  logic [1:0]                    snp_cmd,
    input  logic [IDX_W+TAG_W-1:0]        snp_addr,
    output logic                          snp_flush,
    output logic                          snp_stall
);
    localparam int ADDR_W = IDX_W + TAG_W;
    localparam int LINES  = 1 << IDX_W;

    line_st_t           st_q   [LINES];
    logic [TAG_W-1:0]   ptag_q [LINES];
    logic [TAG_W-1:0]   stag_q [LINES];
    logic               busy_q, done_q, vic_q;
    logic [IDX_W-1:0]   pidx_q;
    logic [TAG_W-1:0]   ptg_q;
    logic [ADDR_W-1:0]  vic_addr_q;

    logic [IDX_W-1:0]   ridx, sidx;
    logic [TAG_W-1:0]   rtag, stg;
    line_st_t           cur_p;
    logic               acc, txn, snp_do, vic_hit;
    bus_cmd_t           cmd_e, snp_cmd_e;

    logic     lk_done, lk_upd, lk_miss, lk_victim;
    line_st_t lk_nxt;
    logic     sn_chg, sn_flush;
    line_st_t sn_nxt;

    assign ridx      = cpu_addr[IDX_W-1:0];
    assign rtag      = cpu_addr[ADDR_W-1:IDX_W];
    assign sidx      = snp_addr[IDX_W-1:0];
    assign stg       = snp_addr[ADDR_W-1:IDX_W];
    assign cur_p     = st_q[pidx_q];
    assign snp_cmd_e = bus_cmd_t'(snp_cmd);

    coh_lookup u_lookup (
        .cur_st   (st_q[ridx]),
        .tag_hit  (ptag_q[ridx] == rtag),
        .wr       (cpu_wr),
        .done_now (lk_done),
        .upd      (lk_upd),
        .nxt_st   (lk_nxt),
        .miss     (lk_miss),
        .victim   (lk_victim)
    );

    coh_snoop u_snoop (
        .cur_st  (st_q[sidx]),
        .tag_hit (stag_q[sidx] == stg),
        .cmd     (snp_cmd_e),
        .nxt_st  (sn_nxt),
        .chg     (sn_chg),
        .flush   (sn_flush)
    );

    // Output / decision process
    always_comb begin
        unique case (cur_p)
            ST_SM:   cmd_e = CMD_UPG;
            ST_IM:   cmd_e = CMD_RDX;
            ST_IS:   cmd_e = CMD_RD;
            default: cmd_e = CMD_NONE;
        endcase
        bus_req     = busy_q && (cmd_e != CMD_NONE);
        bus_cmd     = bus_req ? cmd_e : CMD_NONE;
        bus_addr    = {ptg_q, pidx_q};
        txn         = bus_req && bus_grant;
        bus_wb      = txn && vic_q;
        bus_wb_addr = vic_addr_q;
        cpu_ready   = !busy_q;
        cpu_done    = done_q;
        acc         = cpu_req && !busy_q;
        snp_stall   = snp_valid && !txn &&
                      (acc || (done_q && snp_addr == {ptg_q, pidx_q}));
        snp_do      = snp_valid && !txn && !snp_stall && (snp_cmd_e != CMD_NONE);
        vic_hit     = vic_q && (snp_addr == vic_addr_q);
        snp_flush   = snp_do && (sn_flush || vic_hit);
    end

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                st_q[i]   <= ST_I;
                ptag_q[i] <= '0;
                stag_q[i] <= '0;
            end
            busy_q     <= 1'b0;
            done_q     <= 1'b0;
            vic_q      <= 1'b0;
            pidx_q     <= '0;
            ptg_q      <= '0;
            vic_addr_q <= '0;
        end else begin
            if (done_q) begin
                done_q <= 1'b0;
                busy_q <= 1'b0;
            end
            if (acc) begin
                busy_q <= 1'b1;
                pidx_q <= ridx;
                ptg_q  <= rtag;
                if (lk_done) done_q <= 1'b1;
                if (lk_upd)  st_q[ridx] <= lk_nxt;
                if (lk_miss) begin
                    ptag_q[ridx] <= rtag;
                    stag_q[ridx] <= rtag;
                end
                if (lk_victim) begin
                    vic_q      <= 1'b1;
                    vic_addr_q <= {ptag_q[ridx], ridx};
                end
            end
            if (txn) begin
                st_q[pidx_q] <= (cur_p == ST_IS) ? ST_S : ST_M;
                done_q       <= 1'b1;
                vic_q        <= 1'b0;
            end
            if (snp_do) begin
                if (sn_chg)  st_q[sidx] <= sn_nxt;
                if (vic_hit) vic_q <= 1'b0;
            end
        end
    end

    // Assertions
    a_r3_req_has_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_cmd != CMD_NONE));
    a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_grant) |=> bus_req);
    a_r5_race_to_rdx: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_grant && bus_cmd == CMD_UPG && snp_valid && !snp_stall &&
         snp_addr == bus_addr && (snp_cmd == CMD_RDX || snp_cmd == CMD_UPG))
        |=> (bus_cmd == CMD_RDX));
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);
    a_r6_done_after_txn: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_grant) |=> cpu_done);
    a_r6_busy_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |-> !cpu_ready);
    a_r9_stall_no_flush: assert property (@(posedge clk) disable iff (!rst_n)
        snp_stall |-> !snp_flush);
    a_r11_wb_in_grant: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wb |-> (bus_req && bus_grant));
    a_r12_no_snoop_in_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_grant) |-> (!snp_flush && !snp_stall));

endmodule

// File: tb/tb_coh_ctrl.sv
`timescale 1ns/100ps
module tb_coh_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_req = 1'b0, cpu_wr = 1'b0;
    logic [7:0] cpu_addr = '0;
    logic       cpu_ready, cpu_done, bus_req, bus_wb, snp_flush, snp_stall;
    logic       bus_grant = 1'b0;
    logic [1:0] bus_cmd;
    logic [7:0] bus_addr, bus_wb_addr;
    logic       snp_valid = 1'b0;
    logic [1:0] snp_cmd = '0;
    logic [7:0] snp_addr = '0;

    always #2.5 clk = ~clk;

    coh_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_ready(cpu_ready), .cpu_done(cpu_done),
        .bus_req(bus_req), .bus_grant(bus_grant), .bus_cmd(bus_cmd),
        .bus_addr(bus_addr), .bus_wb(bus_wb), .bus_wb_addr(bus_wb_addr),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .snp_flush(snp_flush), .snp_stall(snp_stall)
    );

    int    nchk = 0, nerr = 0;
    string cur = "R1";
    bit    live = 1'b0;

    // Reference model: per-line state code and tag, pending request
    int ms [4];
    int mt [4];
    int mbusy, mdone, mpa, mvd, mva;
    int e_req, e_cmd, e_txn, e_ready, e_acc, e_stall, e_proc, e_flush, e_wb;

    task automatic model_eval();
        int pi, si, stg;
        pi      = mpa % 4;
        e_req   = (mbusy != 0 && ms[pi] >= 3) ? 1 : 0;
        e_cmd   = !e_req ? 0 : (ms[pi] == 3 ? 3 : (ms[pi] == 4 ? 2 : 1));
        e_txn   = (e_req != 0 && bus_grant) ? 1 : 0;
        e_ready = (mbusy == 0) ? 1 : 0;
        e_acc   = (cpu_req && mbusy == 0) ? 1 : 0;
        e_stall = (snp_valid && e_txn == 0 &&
                   (e_acc != 0 || (mdone != 0 && int'(snp_addr) == mpa))) ? 1 : 0;
        e_proc  = (snp_valid && e_txn == 0 && e_stall == 0 && snp_cmd != 0) ? 1 : 0;
        si      = int'(snp_addr) % 4;
        stg     = int'(snp_addr) / 4;
        e_flush = (e_proc != 0 && ((mt[si] == stg && ms[si] == 2) ||
                   (mvd != 0 && int'(snp_addr) == mva))) ? 1 : 0;
        e_wb    = (e_txn != 0 && mvd != 0) ? 1 : 0;
    endtask

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin
            ms[i] = 0;
            mt[i] = 0;
        end
        mbusy = 0; mdone = 0; mpa = 0; mvd = 0; mva = 0;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            int ri, rt, si, stg, pi;
            model_eval();
            pi = mpa % 4;
            if (mdone != 0) begin
                mdone = 0;
                mbusy = 0;
            end
            if (e_acc != 0) begin
                ri = int'(cpu_addr) % 4;
                rt = int'(cpu_addr) / 4;
                mbusy = 1;
                mpa = int'(cpu_addr);
                if (mt[ri] == rt && (ms[ri] == 1 || ms[ri] == 2)) begin
                    if (!cpu_wr || ms[ri] == 2) mdone = 1;
                    else ms[ri] = 3;
                end else begin
                    if (ms[ri] == 2) begin
                        mvd = 1;
                        mva = mt[ri] * 4 + ri;
                    end
                    mt[ri] = rt;
                    ms[ri] = cpu_wr ? 4 : 5;
                end
            end
            if (e_txn != 0) begin
                ms[pi] = (ms[pi] == 5) ? 1 : 2;
                mdone = 1;
                mvd = 0;
            end
            if (e_proc != 0) begin
                si  = int'(snp_addr) % 4;
                stg = int'(snp_addr) / 4;
                if (mt[si] == stg) begin
                    if (ms[si] == 2) ms[si] = (snp_cmd == 1) ? 1 : 0;
                    else if (ms[si] == 1 && snp_cmd != 1) ms[si] = 0;
                    else if (ms[si] == 3 && snp_cmd != 1) ms[si] = 4;
                end
                if (mvd != 0 && int'(snp_addr) == mva) mvd = 0;
            end
        end
    end

    task automatic chk(string r, string nm, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s actual %0d expected %0d", r, nm, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (live) begin
            model_eval();
            chk(cur, "cpu_ready", int'(cpu_ready), e_ready);
            chk(cur, "cpu_done",  int'(cpu_done),  mdone);
            chk(cur, "bus_req",   int'(bus_req),   e_req);
            chk(cur, "bus_cmd",   int'(bus_cmd),   e_cmd);
            if (e_req != 0) chk(cur, "bus_addr", int'(bus_addr), mpa);
            chk(cur, "bus_wb",    int'(bus_wb),    e_wb);
            if (e_wb != 0) chk(cur, "bus_wb_addr", int'(bus_wb_addr), mva);
            chk(cur, "snp_flush", int'(snp_flush), e_flush);
            chk(cur, "snp_stall", int'(snp_stall), e_stall);
        end
    end

    // One cycle of stimulus, set just after the falling edge
    task automatic go(bit cr, bit cw, int ca, bit gr, bit sv, int sc, int sa);
        @(negedge clk);
        cpu_req = cr; cpu_wr = cw; cpu_addr = 8'(ca);
        bus_grant = gr;
        snp_valid = sv; snp_cmd = 2'(sc); snp_addr = 8'(sa);
    endtask
    task automatic idle();
        go(0, 0, 0, 0, 0, 0, 0);
    endtask

    localparam int A = 8'h15, B = 8'h22, C = 8'h33, D = 8'h40, E = 8'h82;

    initial begin
        repeat (5000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        #1;
        cur = "R1";
        chk("R1", "cpu_ready", int'(cpu_ready), 1);
        chk("R1", "bus_req",   int'(bus_req),   0);
        chk("R1", "cpu_done",  int'(cpu_done),  0);
        @(negedge clk);
        rst_n = 1'b1;
        live  = 1'b1;

        // R3: read miss -> IS, RD, grant -> S
        cur = "R3";
        go(1, 0, A, 0, 0, 0, 0);
        idle(); #1 chk("R3", "bus_cmd", int'(bus_cmd), 1);
        idle(); #1 chk("R3", "bus_req held", int'(bus_req), 1);
        go(0, 0, 0, 1, 0, 0, 0);
        idle(); #1 chk("R6", "cpu_done", int'(cpu_done), 1);
        cur = "R6";
        idle(); #1 chk("R6", "done pulse", int'(cpu_done), 0);

        // R2: read hit in S
        cur = "R2";
        go(1, 0, A, 0, 0, 0, 0);
        idle(); #1 chk("R2", "cpu_done", int'(cpu_done), 1);
        chk("R2", "bus_req", int'(bus_req), 0);
        idle();

        // R4: write hit in S -> SM, UPG
        cur = "R4";
        go(1, 1, A, 0, 0, 0, 0);
        idle(); #1 chk("R4", "bus_cmd", int'(bus_cmd), 3);
        go(0, 0, 0, 1, 0, 0, 0);
        idle(); idle();

        // R2: write hit in M
        cur = "R2";
        go(1, 1, A, 0, 0, 0, 0);
        idle(); #1 chk("R2", "cpu_done", int'(cpu_done), 1);
        idle();

        // R7: snoop RD on M, then RDX on S
        cur = "R7";
        go(0, 0, 0, 0, 1, 1, A); #1 chk("R7", "flush from M", int'(snp_flush), 1);
        go(0, 0, 0, 0, 1, 2, A); #1 chk("R7", "flush from S", int'(snp_flush), 0);
        idle();
        go(1, 0, A, 0, 0, 0, 0);
        idle(); #1 chk("R7", "line now I", int'(bus_cmd), 1);
        go(0, 0, 0, 1, 0, 0, 0);
        idle(); idle();

        // R5: upgrade race, SM snoops UPG on same block
        cur = "R5";
        go(1, 1, A, 0, 0, 0, 0);
        go(0, 0, 0, 0, 1, 3, A); #1 chk("R5", "bus_cmd before", int'(bus_cmd), 3);
        idle(); #1 chk("R5", "bus_cmd after race", int'(bus_cmd), 2);
        go(0, 0, 0, 1, 0, 0, 0);
        idle(); idle();

        // R8: IS ignores own-block snoop, other lines react
        cur = "R8";
        go(1, 0, C, 0, 0, 0, 0);
        go(0, 0, 0, 0, 1, 2, C); #1 chk("R8", "no flush own", int'(snp_flush), 0);
        go(0, 0, 0, 0, 1, 1, A); #1 chk("R8", "other M flush", int'(snp_flush), 1);
        idle(); #1 chk("R8", "still RD", int'(bus_cmd), 1);
        go(0, 0, 0, 1, 0, 0, 0);
        idle(); idle();

        // R9: stall in completion cycle of a fresh exclusive line
        cur = "R9";
        go(1, 1, D, 0, 0, 0, 0);
        idle();
        go(0, 0, 0, 1, 0, 0, 0);
        go(0, 0, 0, 0, 1, 2, D); #1 chk("R9", "stall", int'(snp_stall), 1);
        chk("R9", "no flush", int'(snp_flush), 0);
        go(0, 0, 0, 0, 1, 2, D); #1 chk("R9", "retry flush", int'(snp_flush), 1);
        idle();

        // R10: snoop stalled in acceptance cycle
        cur = "R10";
        go(1, 0, C, 0, 1, 2, A); #1 chk("R10", "stall", int'(snp_stall), 1);
        go(0, 0, 0, 0, 1, 2, A); #1 chk("R10", "retry", int'(snp_stall), 0);
        idle();

        // R11: dirty victim written back in grant cycle
        cur = "R11";
        go(1, 1, B, 0, 0, 0, 0);
        idle();
        go(0, 0, 0, 1, 0, 0, 0);
        idle(); idle();
        go(1, 0, E, 0, 0, 0, 0);
        idle();
        go(0, 0, 0, 1, 0, 0, 0); #1 chk("R11", "bus_wb", int'(bus_wb), 1);
        chk("R11", "bus_wb_addr", int'(bus_wb_addr), B);
        idle(); idle();
        // victim snooped before grant
        go(1, 1, E, 0, 0, 0, 0);
        idle();
        go(0, 0, 0, 1, 0, 0, 0);
        idle(); idle();
        go(1, 0, B, 0, 0, 0, 0);
        go(0, 0, 0, 0, 1, 1, E); #1 chk("R11", "victim flush", int'(snp_flush), 1);
        go(0, 0, 0, 1, 0, 0, 0); #1 chk("R11", "no wb", int'(bus_wb), 0);
        idle(); idle();

        // R12: snoop ignored in own grant cycle
        cur = "R12";
        go(1, 1, C, 0, 0, 0, 0);
        idle();
        go(0, 0, 0, 1, 0, 0, 0);
        idle(); idle();
        go(1, 0, A, 0, 0, 0, 0);
        idle();
        go(0, 0, 0, 1, 1, 1, C); #1 chk("R12", "no flush in grant", int'(snp_flush), 0);
        idle(); idle();
        go(0, 0, 0, 0, 1, 1, C); #1 chk("R12", "line still M", int'(snp_flush), 1);
        idle(); idle();

        live = 1'b0;
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule